// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits in an SDRAM controller's command path. It holds a small burst mode word, loaded by a mode-register write. From each read or write column command it then produces the column address for every beat of the burst. The start column is presented in the command cycle itself, and each later beat follows on the next clock.

The order of the low column bits is chosen by the mode word. Sequential order counts up and wraps inside an aligned block of burst-length size. Interleaved order XORs the beat number into the start column. A full-page mode walks all 256 columns, wrapping, until a stop command arrives. A separate mode bit can limit writes to a single beat while reads keep the programmed length.

For reads, the block delays a beat marker by the programmed CAS latency to produce the data-valid flag. It also delays the byte masks by two cycles to form per-byte output enables. For writes, the byte masks gate the write enables in the same cycle. A new column command cuts off the running burst and restarts at its own column. A burst-stop or precharge strobe ends the burst, and beats already in the latency pipe are still delivered.

Top module: `sdr_burst_seq`

## Requirements
- R1: A mode write with a legal word clears `mode_err` on the next cycle and sets the mode used from the next cycle. The word's fields are: bits 2:0 burst length (000=1, 001=2, 010=4, 011=8, 111=full page); bit 3 order (0 sequential, 1 interleaved); bits 6:4 CAS latency (001=1, 010=2, 011=3); bits 8:7 reserved, must be 0; bit 9 write-single.
- R2: A mode word is rejected when any of these holds: its length code is reserved, its latency code is reserved, its reserved bits are nonzero, or it asks for full page with interleaved order. A rejected word sets `mode_err` on the next cycle and leaves the previous mode in force.
- R3: In sequential order, beat k has column {start[7:w], (start[w-1:0]+k) mod 2^w}, where w = log2(burst length).
- R4: In interleaved order, beat k has column start XOR k.
- R5: In full-page mode, beat k has column (start+k) mod 256. The burst continues until it is stopped.
- R6: With bit 9 set, a write burst has exactly one beat. Reads still use the programmed length.
- R7: Beat 0 appears on `col_addr` with `burst_act` high in the command cycle. `burst_act` then stays high for exactly burst-length consecutive cycles. `col_addr` is 0 whenever `burst_act` is low.
- R8: `rd_valid` is high exactly CL cycles after each cycle in which a read beat is issued.
- R9: A read or write command during a burst ends the old burst. A new sequence starts at the new column in that cycle.
- R10: A stop or precharge strobe with no column command suppresses the beat of its own cycle and every later beat. With CL=3 the last data is due two cycles after the strobe; with CL=2, one cycle after.
- R11: `rd_oe[i]` is high when `rd_valid` is high and `dqm[i]` was low two cycles earlier; otherwise it is low.
- R12: `wr_be[i]` is high when a write beat is issued and `dqm[i]` is low in the same cycle.
- R13: After reset all outputs are low. The mode is burst length 1, sequential order, CL=2, write-single off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mrs_stb | input | 1 | Mode word write strobe |
| mrs_op | input | 10 | Mode word |
| rd_cmd | input | 1 | Read column command (wins over write) |
| wr_cmd | input | 1 | Write column command |
| bst_cmd | input | 1 | Burst stop strobe |
| pre_cmd | input | 1 | Precharge strobe, also stops the burst |
| col_in | input | 8 | Start column of the command |
| dqm | input | 2 | Byte masks, bit 0 low byte |
| col_addr | output | 8 | Column of the current beat |
| burst_act | output | 1 | A beat is issued this cycle |
| burst_wr | output | 1 | The current beat is a write |
| rd_valid | output | 1 | Read data due this cycle |
| rd_oe | output | 2 | Per-byte read output enables |
| wr_be | output | 2 | Per-byte write enables |
| mode_err | output | 1 | Last mode word was rejected |

## Verification
The address, `burst_act` and `wr_be` come from combinational logic, so they belong to the cycle in which the command is driven. The bench drives just after a rising edge and samples at the following falling edge of that same cycle. `rd_valid` and `rd_oe` are due CL cycles after each beat. `mode_err` and a new mode take effect one cycle after the mode strobe. The bench's expected values count beats from the command cycle and shift them by the latency, and they mark the stop cycle as the first beat not issued. Each check samples at the falling edge of the cycle where its effect is due.

// File: rtl/sdr_seq_pkg.sv
// Shared widths and the decoded burst mode type for the column sequencer.
// Assumes 8-bit columns, two byte lanes and CAS latency up to 3.
package sdr_seq_pkg;
    localparam int SEQ_COL_W    = 8;
    localparam int SEQ_NB       = 2;
    localparam int SEQ_MAX_CL   = 3;
    localparam int SEQ_MASK_DLY = 2;
    localparam int SEQ_OP_W     = 10;
    localparam int SEQ_CL_W     = $clog2(SEQ_MAX_CL + 1);

    typedef struct packed {
        logic [SEQ_COL_W-1:0] len_mask;  // burst length minus one
        logic                 full;      // full-page burst
        logic                 inter;     // interleaved order
        logic [SEQ_CL_W-1:0]  cl;        // CAS latency in cycles
        logic                 wr_single; // writes use one beat
    } seq_mode_t;
endpackage

// File: rtl/sdr_mode_reg.sv
// Mode word decoder and holding register.
// Accepts a legal word on mrs_stb; rejects reserved codes, keeping the old mode.
// Assumes the controller writes the mode only while no burst is running.
module sdr_mode_reg
    import sdr_seq_pkg::*;
#(
    parameter int OP_W  = SEQ_OP_W,
    parameter int COL_W = SEQ_COL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mrs_stb,
    input  logic [OP_W-1:0] mrs_op,
    output seq_mode_t       mode_q,
    output logic            mode_err
);
    logic      full_code, bl_ok, cl_ok, rsv_ok, legal;
    seq_mode_t new_mode;

    // Decode the incoming word and judge whether it is legal.
    always_comb begin
        full_code = (mrs_op[2:0] == 3'b111);
        bl_ok     = !mrs_op[2] || full_code;
        cl_ok     = !mrs_op[6] && (mrs_op[5:4] != 2'b00);
        rsv_ok    = (mrs_op[8:7] == 2'b00);
        legal     = bl_ok && cl_ok && rsv_ok && !(full_code && mrs_op[3]);
        new_mode.len_mask  = full_code ? {COL_W{1'b1}}
                                       : (COL_W'(1) << mrs_op[1:0]) - COL_W'(1);
        new_mode.full      = full_code;
        new_mode.inter     = mrs_op[3];
        new_mode.cl        = mrs_op[5:4];
        new_mode.wr_single = mrs_op[OP_W-1];
    end

    // Hold the active mode and the rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '{len_mask: '0, full: 1'b0, inter: 1'b0, cl: 2'd2, wr_single: 1'b0};
            mode_err <= 1'b0;
        end else if (mrs_stb) begin
            mode_err <= !legal;
            if (legal) mode_q <= new_mode;
        end
    end

    // R2
    bad_mode_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_stb && mrs_op[2:0] == 3'b100) |=> (mode_err && $stable(mode_q)));
    // R1
    good_mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_stb && mrs_op == 10'h022) |=> (!mode_err && mode_q.cl == 2'd2));
endmodule

// File: rtl/sdr_col_gen.sv
// Per-beat column generator. Beat 0 is issued combinationally in the command
// cycle; later beats come from registered start, count and burst shape.
// Assumes rd_cmd wins over wr_cmd, and a column command wins over a stop.
module sdr_col_gen
    import sdr_seq_pkg::*;
#(
    parameter int COL_W = SEQ_COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_mode_t        mode,
    input  logic             rd_cmd,
    input  logic             wr_cmd,
    input  logic             term,
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_addr,
    output logic             beat,
    output logic             beat_wr
);
    logic             act_q, wr_q, full_q, inter_q;
    logic [COL_W-1:0] start_q, cnt_q, mask_q;
    logic             cmd, cmd_wr, one_wr;
    logic [COL_W-1:0] cmd_mask, cur_start, cur_k, cur_mask;
    logic             cmd_full, cur_inter;

    // Shape of a burst that starts this cycle.
    always_comb begin
        cmd      = rd_cmd || wr_cmd;
        cmd_wr   = wr_cmd && !rd_cmd;
        one_wr   = cmd_wr && mode.wr_single;
        cmd_mask = one_wr ? '0 : mode.len_mask;
        cmd_full = mode.full && !one_wr;
    end

    // Select the beat of this cycle and form its column.
    always_comb begin
        beat      = 1'b0;
        beat_wr   = 1'b0;
        cur_start = start_q;
        cur_k     = cnt_q;
        cur_mask  = mask_q;
        cur_inter = inter_q;
        if (cmd) begin
            beat      = 1'b1;
            beat_wr   = cmd_wr;
            cur_start = col_in;
            cur_k     = '0;
            cur_mask  = cmd_mask;
            cur_inter = mode.inter;
        end else if (act_q && !term) begin
            beat    = 1'b1;
            beat_wr = wr_q;
        end
        if (!beat)
            col_addr = '0;
        else if (cur_inter)
            col_addr = cur_start ^ cur_k;
        else
            col_addr = (cur_start & ~cur_mask) | ((cur_start + cur_k) & cur_mask);
    end

    // Burst state: start, restart, advance, end or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            wr_q    <= 1'b0;
            full_q  <= 1'b0;
            inter_q <= 1'b0;
            start_q <= '0;
            cnt_q   <= '0;
            mask_q  <= '0;
        end else if (cmd) begin
            act_q   <= cmd_full || (cmd_mask != '0);
            wr_q    <= cmd_wr;
            full_q  <= cmd_full;
            inter_q <= mode.inter;
            start_q <= col_in;
            cnt_q   <= COL_W'(1);
            mask_q  <= cmd_mask;
        end else if (term) begin
            act_q <= 1'b0;
        end else if (act_q) begin
            if (!full_q && cnt_q == mask_q) act_q <= 1'b0;
            cnt_q <= cnt_q + COL_W'(1);
        end
    end

    // R3
    seq_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !cmd && !term && !inter_q && !full_q)
            |-> (((col_addr ^ start_q) & ~mask_q) == '0));
    // R5
    full_page_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && full_q && !cmd && !term) |=> act_q);
    // R10
    stop_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !cmd) |=> !act_q);
endmodule

// File: rtl/sdr_rd_pipe.sv
// Read latency pipe: delays the read-beat marker by the CAS latency and the
// byte masks by a fixed two cycles, then forms per-byte output enables.
// Assumes the latency is not changed while read beats are in flight.
module sdr_rd_pipe
    import sdr_seq_pkg::*;
#(
    parameter int MAX_CL = SEQ_MAX_CL,
    parameter int NB     = SEQ_NB,
    parameter int CL_W   = SEQ_CL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            beat_rd,
    input  logic [CL_W-1:0] cl,
    input  logic [NB-1:0]   dqm,
    output logic            rd_valid,
    output logic [NB-1:0]   rd_oe
);
    localparam int DLY = SEQ_MASK_DLY;

    logic [MAX_CL-1:0] vld_sr;
    logic [NB-1:0]     dqm_sr [DLY];

    // Shift the read-beat marker one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_sr <= '0;
        else        vld_sr <= {vld_sr[MAX_CL-2:0], beat_rd};
    end

    // Mask delay line, one register stage per cycle of delay.
    for (genvar g = 0; g < DLY; g++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n)      dqm_sr[g] <= '0;
            else if (g == 0) dqm_sr[g] <= dqm;
            else             dqm_sr[g] <= dqm_sr[(g == 0) ? 0 : g - 1];
        end
    end

    // Tap the marker at the programmed latency and gate the byte enables.
    always_comb begin
        rd_valid = 1'b0;
        for (int i = 0; i < MAX_CL; i++)
            if (int'(cl) == i + 1) rd_valid = vld_sr[i];
        rd_oe = {NB{rd_valid}} & ~dqm_sr[DLY-1];
    end

    // R8
    cl1_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_rd && cl == 2'd1) |=> rd_valid);
    // R8
    cl3_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_rd && cl == 2'd3) |=> ##2 (rd_valid || cl != 2'd3));
    // R11
    oe_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(dqm, 2) == '0) |-> (rd_oe == '1));
endmodule

// File: rtl/sdr_burst_seq.sv
// Top of the burst column sequencer: mode register, column generator and
// read latency pipe, with same-cycle write byte enables.
// Assumes one command per cycle from a controller that obeys spacing rules.
module sdr_burst_seq
    import sdr_seq_pkg::*;
#(
    parameter int COL_W = SEQ_COL_W,
    parameter int NB    = SEQ_NB,
    parameter int OP_W  = SEQ_OP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_stb,
    input  logic [OP_W-1:0]  mrs_op,
    input  logic             rd_cmd,
    input  logic             wr_cmd,
    input  logic             bst_cmd,
    input  logic             pre_cmd,
    input  logic [COL_W-1:0] col_in,
    input  logic [NB-1:0]    dqm,
    output logic [COL_W-1:0] col_addr,
    output logic             burst_act,
    output logic             burst_wr,
    output logic             rd_valid,
    output logic [NB-1:0]    rd_oe,
    output logic [NB-1:0]    wr_be,
    output logic             mode_err
);
    seq_mode_t mode;

    sdr_mode_reg #(.OP_W(OP_W), .COL_W(COL_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .mrs_stb(mrs_stb), .mrs_op(mrs_op),
        .mode_q(mode), .mode_err(mode_err)
    );

    sdr_col_gen #(.COL_W(COL_W)) u_col (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .term(bst_cmd || pre_cmd), .col_in(col_in), .col_addr(col_addr),
        .beat(burst_act), .beat_wr(burst_wr)
    );

    sdr_rd_pipe #(.NB(NB)) u_rd (
        .clk(clk), .rst_n(rst_n), .beat_rd(burst_act && !burst_wr),
        .cl(mode.cl), .dqm(dqm), .rd_valid(rd_valid), .rd_oe(rd_oe)
    );

    // Write masks act in the beat's own cycle.
    always_comb wr_be = {NB{burst_act && burst_wr}} & ~dqm;

    // R12
    wr_be_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_be != '0) |-> (burst_act && burst_wr));
endmodule

// File: tb/test_sdr_burst_seq.sv
module test_sdr_burst_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mrs_stb = 1'b0;
    logic [9:0] mrs_op = '0;
    logic       rd_cmd = 1'b0, wr_cmd = 1'b0, bst_cmd = 1'b0, pre_cmd = 1'b0;
    logic [7:0] col_in = '0;
    logic [1:0] dqm = '0;
    logic [7:0] col_addr;
    logic       burst_act, burst_wr, rd_valid, mode_err;
    logic [1:0] rd_oe, wr_be;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    sdr_burst_seq i_sdr_burst_seq (
        .clk(clk), .rst_n(rst_n), .mrs_stb(mrs_stb), .mrs_op(mrs_op),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .bst_cmd(bst_cmd), .pre_cmd(pre_cmd),
        .col_in(col_in), .dqm(dqm), .col_addr(col_addr), .burst_act(burst_act),
        .burst_wr(burst_wr), .rd_valid(rd_valid), .rd_oe(rd_oe), .wr_be(wr_be),
        .mode_err(mode_err)
    );

    task automatic chk(string req, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // One cycle: drive just after the edge, sample at the falling edge.
    task automatic cyc(bit m, logic [9:0] op, bit r, bit w, bit b, bit p,
                       logic [7:0] c, logic [1:0] d);
        @(posedge clk);
        #1;
        mrs_stb = m; mrs_op = op; rd_cmd = r; wr_cmd = w;
        bst_cmd = b; pre_cmd = p; col_in = c; dqm = d;
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_mrs(string req, logic [9:0] op, bit exp_err);
        cyc(1, op, 0, 0, 0, 0, 0, 0);
        idle();
        chk(req, "mode_err", int'(mode_err), int'(exp_err));
    endtask

    // Generic burst with optional stop at cycle term_at (by precharge if use_pre).
    task automatic do_burst(string req, bit is_wr, logic [7:0] col, int bl,
                            bit inter, int cl, int ncyc, int term_at, bit use_pre);
        int nb = (bl < term_at) ? bl : term_at;
        int mask = (bl >= 256) ? 255 : bl - 1;
        for (int k = 0; k < ncyc; k++) begin
            bit eb, erv;
            int ecol;
            if (k == 0) cyc(0, 0, !is_wr, is_wr, 0, 0, col, 0);
            else cyc(0, 0, 0, 0, (k == term_at) && !use_pre, (k == term_at) && use_pre, 0, 0);
            eb = (k < nb);
            if (!eb) ecol = 0;
            else if (inter) ecol = int'(col) ^ k;
            else ecol = (int'(col) & ~mask) | ((int'(col) + k) & mask);
            erv = !is_wr && (k >= cl) && (k - cl < nb);
            chk(req, "burst_act", int'(burst_act), int'(eb));
            chk(req, "col_addr", int'(col_addr), ecol);
            chk(req, "rd_valid", int'(rd_valid), int'(erv));
            chk(req, "rd_oe", int'(rd_oe), erv ? 3 : 0);
            chk(req, "wr_be", int'(wr_be), (is_wr && eb) ? 3 : 0);
        end
    endtask

    task automatic t_reset();
        // R13 reset values
        chk("R13", "burst_act", int'(burst_act), 0);
        chk("R13", "rd_valid", int'(rd_valid), 0);
        chk("R13", "mode_err", int'(mode_err), 0);
        chk("R13", "col_addr", int'(col_addr), 0);
        // R13 default mode: BL1, CL2
        do_burst("R13", 0, 8'h5A, 1, 0, 2, 4, 999, 0);
    endtask

    task automatic t_seq();
        do_mrs("R1", 10'h022, 0);                         // BL4 seq CL2
        do_burst("R3", 0, 8'h0D, 4, 0, 2, 8, 999, 0);
        do_burst("R7", 1, 8'h0D, 4, 0, 2, 6, 999, 0);
    endtask

    task automatic t_inter();
        do_mrs("R1", 10'h03B, 0);                         // BL8 il CL3
        do_burst("R4", 0, 8'h35, 8, 1, 3, 12, 999, 0);
    endtask

    task automatic t_wsingle();
        do_mrs("R1", 10'h213, 0);                         // BL8 seq CL1, single write
        do_burst("R6", 1, 8'h44, 1, 0, 1, 4, 999, 0);
        do_burst("R8", 0, 8'h44, 8, 0, 1, 11, 999, 0);
    endtask

    task automatic t_full();
        do_mrs("R1", 10'h037, 0);                         // full page CL3
        do_burst("R5", 0, 8'hFE, 100000, 0, 3, 264, 258, 0);
    endtask

    task automatic t_term_cl2();
        do_mrs("R1", 10'h023, 0);                         // BL8 seq CL2
        do_burst("R10", 0, 8'h08, 8, 0, 2, 8, 3, 1);
    endtask

    task automatic t_illegal();
        do_mrs("R2", 10'h024, 1);                         // reserved length
        do_mrs("R2", 10'h002, 1);                         // reserved latency
        do_mrs("R2", 10'h03F, 1);                         // full page + interleave
        do_mrs("R2", 10'h0A2, 1);                         // reserved bit set
        do_burst("R2", 0, 8'h08, 8, 0, 2, 11, 999, 0);   // old mode BL8 CL2
        do_mrs("R1", 10'h022, 0);
    endtask

    task automatic t_interrupt();
        int ecol [6] = '{'h10, 'h22, 'h23, 'h20, 'h21, 0};
        for (int k = 0; k < 8; k++) begin
            if (k == 0) cyc(0, 0, 1, 0, 0, 0, 8'h10, 0);
            else if (k == 1) cyc(0, 0, 1, 0, 0, 0, 8'h22, 0);
            else idle();
            if (k < 6) chk("R9", "col_addr", int'(col_addr), ecol[k]);
            if (k < 6) chk("R9", "burst_act", int'(burst_act), int'(k < 5));
            chk("R9", "rd_valid", int'(rd_valid), int'(k >= 2 && k <= 6));
        end
    endtask

    task automatic t_mask();
        logic [1:0] erd [6] = '{2'b00, 2'b00, 2'b11, 2'b10, 2'b11, 2'b11};
        logic [1:0] dw  [5] = '{2'b00, 2'b10, 2'b11, 2'b00, 2'b00};
        logic [1:0] ewr [5] = '{2'b11, 2'b01, 2'b00, 2'b11, 2'b00};
        for (int k = 0; k < 6; k++) begin
            cyc(0, 0, k == 0, 0, 0, 0, 0, (k == 1) ? 2'b01 : 2'b00);
            chk("R11", "rd_oe", int'(rd_oe), int'(erd[k]));
        end
        for (int k = 0; k < 5; k++) begin
            cyc(0, 0, 0, k == 0, 0, 0, 0, dw[k]);
            chk("R12", "wr_be", int'(wr_be), int'(ewr[k]));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seq();
        t_inter();
        t_wsingle();
        t_full();
        t_term_cl2();
        t_illegal();
        t_interrupt();
        t_mask();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule